// File: doc/BRIEF.md
# Shared Bus Register Transfer Datapath

This block is the register file and transfer fabric of a small accumulator machine. It holds an address register, a program counter, a data register, an accumulator, an instruction register, a temporary register and an 8-bit output-character register. All of them meet on one 16-bit bus. A 3-bit select code chooses the single source that drives the bus in a cycle. Sources narrower than the bus are zero-extended, and the memory read port is one of the selectable sources.

Each destination register captures the bus value on the next rising clock edge while its load enable is high. Five of the registers also have increment and clear controls. The accumulator never loads from the bus. Its load takes a result port fed by an external arithmetic unit, so a bus move into another register and an accumulator update can finish on the same edge. The address register always drives the memory address, and the bus value is the memory write data.

The block has no sequencer of its own. An external control unit drives the select code and the per-register enables every cycle.

Top module: `bus_xfer_path`

## Requirements
- R1: The bus carries the source picked by `bus_sel`: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register and 7 `mem_rdata`.
- R2: When a 12-bit source (code 1 or 2) is selected, bus bits 15:12 are zero.
- R3: A register whose load enable is high takes the bus value at the next rising edge. The address register and program counter keep bus bits 11:0, and the output-character register keeps bus bits 7:0.
- R4: On `acc_ld` the accumulator takes `alu_result`, whatever the bus carries.
- R5: On a register with clear, load and increment, clear wins over load and load wins over increment.
- R6: Increment adds one modulo the register width: a 12-bit register goes from 0xFFF to 0x000, and a 16-bit register goes from 0xFFFF to 0x0000.
- R7: A register with none of its controls high keeps its value, including while a memory write is in progress.
- R8: `mem_addr` equals the address register, `mem_wdata` equals the bus, and `mem_we` follows `mem_wr`.
- R9: With select code 4, `data_ld` and `acc_ld` (with `alu_result` fed the data register's value), the data register and accumulator swap on one edge.
- R10: After reset every register reads zero.
- R11: `in_char` never reaches the bus. It is passed unchanged to `alu_char` for the arithmetic unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 3 | Bus source select code |
| mem_rdata | input | 16 | Memory read data, bus source 7 |
| mem_wr | input | 1 | Memory write request |
| alu_result | input | 16 | Accumulator load value from the arithmetic unit |
| in_char | input | 8 | Input character for the arithmetic unit |
| addr_ld | input | 1 | Address register load from bus |
| addr_inc | input | 1 | Address register increment |
| addr_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| data_ld | input | 1 | Data register load from bus |
| data_inc | input | 1 | Data register increment |
| data_clr | input | 1 | Data register clear |
| acc_ld | input | 1 | Accumulator load from `alu_result` |
| acc_inc | input | 1 | Accumulator increment |
| acc_clr | input | 1 | Accumulator clear |
| temp_ld | input | 1 | Temporary register load from bus |
| temp_inc | input | 1 | Temporary register increment |
| temp_clr | input | 1 | Temporary register clear |
| instr_ld | input | 1 | Instruction register load from bus |
| outc_ld | input | 1 | Output-character register load from bus |
| bus_val | output | 16 | Current bus value |
| addr_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| data_q | output | 16 | Data register |
| acc_q | output | 16 | Accumulator |
| instr_q | output | 16 | Instruction register |
| temp_q | output | 16 | Temporary register |
| outc_q | output | 8 | Output-character register |
| alu_char | output | 8 | Input character forwarded to the arithmetic unit |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |

## Verification
Several properties are checked on every cycle:
- zero-extension of the 12-bit sources and the memory source on the bus;
- bus loads into the data and output-character registers;
- accumulator loads from the result port;
- clear beating load on the program counter;
- wrap-around increment on the temporary register;
- the hold behaviour of the accumulator.

The remaining behaviours need particular register contents set up first, so only the directed scenarios show them:
- the full select-code table;
- truncation when a 12-bit register loads;
- load beating increment;
- the one-edge swap of data register and accumulator;
- the memory port connections;
- the isolation of the input character from the bus.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_ADDR  = 3'd1,
        SRC_PC    = 3'd2,
        SRC_DATA  = 3'd3,
        SRC_ACC   = 3'd4,
        SRC_INSTR = 3'd5,
        SRC_TEMP  = 3'd6,
        SRC_MEM   = 3'd7
    } bus_src_e;

endpackage

// File: rtl/bus_select.sv
module bus_select
    import bus_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] instr_in,
    input  logic [DATA_W-1:0] temp_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] bus_out
);
    localparam int EXT_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] addr_ext;
    logic [DATA_W-1:0] pc_ext;

    // narrow sources pad their upper bits with zeros
    generate
        if (EXT_W > 0) begin : g_ext
            assign addr_ext = {{EXT_W{1'b0}}, addr_in};
            assign pc_ext   = {{EXT_W{1'b0}}, pc_in};
        end else begin : g_noext
            assign addr_ext = addr_in[DATA_W-1:0];
            assign pc_ext   = pc_in[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (bus_src_e'(sel))
            SRC_NONE:  bus_out = '0;
            SRC_ADDR:  bus_out = addr_ext;
            SRC_PC:    bus_out = pc_ext;
            SRC_DATA:  bus_out = data_in;
            SRC_ACC:   bus_out = acc_in;
            SRC_INSTR: bus_out = instr_in;
            SRC_TEMP:  bus_out = temp_in;
            SRC_MEM:   bus_out = mem_in;
        endcase
    end
endmodule

// File: rtl/xfer_reg.sv
module xfer_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // priority: clear, then load, then increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (ld)  q <= d;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/bus_xfer_path.sv
module bus_xfer_path
    import bus_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_wr,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              addr_ld,
    input  logic              addr_inc,
    input  logic              addr_clr,
    input  logic              pc_ld,
    input  logic              pc_inc,
    input  logic              pc_clr,
    input  logic              data_ld,
    input  logic              data_inc,
    input  logic              data_clr,
    input  logic              acc_ld,
    input  logic              acc_inc,
    input  logic              acc_clr,
    input  logic              temp_ld,
    input  logic              temp_inc,
    input  logic              temp_clr,
    input  logic              instr_ld,
    input  logic              outc_ld,
    output logic [DATA_W-1:0] bus_val,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] instr_q,
    output logic [DATA_W-1:0] temp_q,
    output logic [CHAR_W-1:0] outc_q,
    output logic [CHAR_W-1:0] alu_char,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    logic [DATA_W-1:0] bus_w;

    bus_select #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
        .sel(bus_sel), .addr_in(addr_q), .pc_in(pc_q), .data_in(data_q),
        .acc_in(acc_q), .instr_in(instr_q), .temp_in(temp_q),
        .mem_in(mem_rdata), .bus_out(bus_w)
    );

    xfer_reg #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .ld(addr_ld), .inc(addr_inc),
        .d(bus_w[ADDR_W-1:0]), .q(addr_q)
    );
    xfer_reg #(.W(ADDR_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .clr(pc_clr), .ld(pc_ld), .inc(pc_inc),
        .d(bus_w[ADDR_W-1:0]), .q(pc_q)
    );
    xfer_reg #(.W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .clr(data_clr), .ld(data_ld), .inc(data_inc),
        .d(bus_w), .q(data_q)
    );
    // accumulator loads from the arithmetic result port, not the bus
    xfer_reg #(.W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .ld(acc_ld), .inc(acc_inc),
        .d(alu_result), .q(acc_q)
    );
    xfer_reg #(.W(DATA_W)) u_temp (
        .clk(clk), .rst_n(rst_n), .clr(temp_clr), .ld(temp_ld), .inc(temp_inc),
        .d(bus_w), .q(temp_q)
    );
    xfer_reg #(.W(DATA_W)) u_instr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(instr_ld), .inc(1'b0),
        .d(bus_w), .q(instr_q)
    );
    xfer_reg #(.W(CHAR_W)) u_outc (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(outc_ld), .inc(1'b0),
        .d(bus_w[CHAR_W-1:0]), .q(outc_q)
    );

    assign bus_val   = bus_w;
    assign alu_char  = in_char;
    assign mem_addr  = addr_q;
    assign mem_wdata = bus_w;
    assign mem_we    = mem_wr;
endmodule

// File: rtl/bus_xfer_path_chk.sv
module bus_xfer_path_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_sel,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] alu_result,
    input logic              pc_clr,
    input logic              pc_ld,
    input logic              data_ld,
    input logic              data_clr,
    input logic              acc_ld,
    input logic              acc_inc,
    input logic              acc_clr,
    input logic              temp_ld,
    input logic              temp_inc,
    input logic              temp_clr,
    input logic              outc_ld,
    input logic [DATA_W-1:0] bus_val,
    input logic [ADDR_W-1:0] pc_q,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] acc_q,
    input logic [DATA_W-1:0] temp_q,
    input logic [CHAR_W-1:0] outc_q
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_val[DATA_W-1:ADDR_W] == '0);

    assert_mem_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd7) |-> bus_val == mem_rdata);

    assert_data_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(data_ld && !data_clr) |-> data_q == $past(bus_val));

    assert_outc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(outc_ld) |-> outc_q == $past(bus_val[CHAR_W-1:0]));

    assert_acc_from_alu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(acc_ld && !acc_clr) |-> acc_q == $past(alu_result));

    assert_clr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(pc_clr && pc_ld) |-> pc_q == '0);

    assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(temp_inc && !temp_ld && !temp_clr)
        |-> temp_q == DATA_W'($past(temp_q) + 1'b1));

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!acc_ld && !acc_inc && !acc_clr) |-> $stable(acc_q));
endmodule

bind bus_xfer_path bus_xfer_path_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)
) chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .mem_rdata(mem_rdata),
    .alu_result(alu_result), .pc_clr(pc_clr), .pc_ld(pc_ld),
    .data_ld(data_ld), .data_clr(data_clr), .acc_ld(acc_ld),
    .acc_inc(acc_inc), .acc_clr(acc_clr), .temp_ld(temp_ld),
    .temp_inc(temp_inc), .temp_clr(temp_clr), .outc_ld(outc_ld),
    .bus_val(bus_val), .pc_q(pc_q), .data_q(data_q), .acc_q(acc_q),
    .temp_q(temp_q), .outc_q(outc_q)
);

// File: tb/bus_xfer_path_test.sv
module bus_xfer_path_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_wr = 1'b0;
    logic [15:0] alu_result = '0;
    logic [7:0]  in_char = '0;
    logic addr_ld = 0, addr_inc = 0, addr_clr = 0;
    logic pc_ld = 0, pc_inc = 0, pc_clr = 0;
    logic data_ld = 0, data_inc = 0, data_clr = 0;
    logic acc_ld = 0, acc_inc = 0, acc_clr = 0;
    logic temp_ld = 0, temp_inc = 0, temp_clr = 0;
    logic instr_ld = 0, outc_ld = 0;
    logic [15:0] bus_val, data_q, acc_q, instr_q, temp_q, mem_wdata;
    logic [11:0] addr_q, pc_q, mem_addr;
    logic [7:0]  outc_q, alu_char;
    logic        mem_we;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bus_xfer_path uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .alu_result(alu_result), .in_char(in_char),
        .addr_ld(addr_ld), .addr_inc(addr_inc), .addr_clr(addr_clr),
        .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
        .data_ld(data_ld), .data_inc(data_inc), .data_clr(data_clr),
        .acc_ld(acc_ld), .acc_inc(acc_inc), .acc_clr(acc_clr),
        .temp_ld(temp_ld), .temp_inc(temp_inc), .temp_clr(temp_clr),
        .instr_ld(instr_ld), .outc_ld(outc_ld),
        .bus_val(bus_val), .addr_q(addr_q), .pc_q(pc_q), .data_q(data_q),
        .acc_q(acc_q), .instr_q(instr_q), .temp_q(temp_q), .outc_q(outc_q),
        .alu_char(alu_char), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {addr_ld, addr_inc, addr_clr, pc_ld, pc_inc, pc_clr} = '0;
        {data_ld, data_inc, data_clr, acc_ld, acc_inc, acc_clr} = '0;
        {temp_ld, temp_inc, temp_clr, instr_ld, outc_ld, mem_wr} = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic t_reset();
        bus_sel = 3'd0;
        #1;
        check("R10 addr", {4'h0, addr_q}, 16'h0);
        check("R10 pc", {4'h0, pc_q}, 16'h0);
        check("R10 data", data_q, 16'h0);
        check("R10 acc", acc_q, 16'h0);
        check("R10 instr", instr_q, 16'h0);
        check("R10 temp", temp_q, 16'h0);
        check("R10 outc", {8'h0, outc_q}, 16'h0);
        check("R1 code0 zero", bus_val, 16'h0);
    endtask

    task automatic t_loads();
        bus_sel = 3'd7; mem_rdata = 16'hA5C3; data_ld = 1; tick();
        check("R3 data load", data_q, 16'hA5C3);
        bus_sel = 3'd3; addr_ld = 1; pc_ld = 1; outc_ld = 1; tick();
        check("R3 addr low12", {4'h0, addr_q}, 16'h05C3);
        check("R3 pc low12", {4'h0, pc_q}, 16'h05C3);
        check("R3 outc low8", {8'h0, outc_q}, 16'h00C3);
        bus_sel = 3'd7; mem_rdata = 16'h1234; instr_ld = 1; tick();
        check("R3 instr load", instr_q, 16'h1234);
        bus_sel = 3'd5; temp_ld = 1; tick();
        check("R3 temp load", temp_q, 16'h1234);
    endtask

    task automatic t_select();
        alu_result = 16'hBEEF; acc_ld = 1; tick();
        temp_inc = 1; tick();
        mem_rdata = 16'h7F01;
        for (int s = 0; s < 8; s++) begin
            logic [15:0] exp;
            bus_sel = 3'(s);
            #1;
            case (s)
                0: exp = 16'h0000;
                1: exp = 16'h05C3;
                2: exp = 16'h05C3;
                3: exp = 16'hA5C3;
                4: exp = 16'hBEEF;
                5: exp = 16'h1234;
                6: exp = 16'h1235;
                default: exp = 16'h7F01;
            endcase
            check((s == 1 || s == 2) ? "R2 zero-extend" : "R1 select map", bus_val, exp);
        end
    endtask

    task automatic t_char();
        in_char = 8'h7E; bus_sel = 3'd0;
        #1;
        check("R11 alu_char", {8'h0, alu_char}, 16'h007E);
        check("R11 bus untouched", bus_val, 16'h0000);
    endtask

    task automatic t_priority();
        bus_sel = 3'd7; mem_rdata = 16'h0ABC;
        pc_clr = 1; pc_ld = 1; pc_inc = 1; tick();
        check("R5 clear wins", {4'h0, pc_q}, 16'h0000);
        pc_ld = 1; pc_inc = 1; tick();
        check("R5 load over inc", {4'h0, pc_q}, 16'h0ABC);
        pc_inc = 1; tick();
        check("R5 inc alone", {4'h0, pc_q}, 16'h0ABD);
    endtask

    task automatic t_wrap();
        bus_sel = 3'd7; mem_rdata = 16'hFFFF; addr_ld = 1; temp_ld = 1; tick();
        addr_inc = 1; temp_inc = 1; tick();
        check("R6 addr wrap", {4'h0, addr_q}, 16'h0000);
        check("R6 temp wrap", temp_q, 16'h0000);
        alu_result = 16'hFFFF; acc_ld = 1; tick();
        acc_inc = 1; tick();
        check("R6 acc wrap", acc_q, 16'h0000);
    endtask

    task automatic t_hold_mem();
        alu_result = 16'h3C3C; acc_ld = 1; tick();
        bus_sel = 3'd7; mem_rdata = 16'h0155; addr_ld = 1; tick();
        bus_sel = 3'd4; mem_wr = 1;
        #1;
        check("R8 mem_we", {15'h0, mem_we}, 16'h0001);
        check("R8 mem_wdata", mem_wdata, 16'h3C3C);
        check("R8 mem_addr", {4'h0, mem_addr}, 16'h0155);
        alu_result = 16'h9999; tick();
        mem_wr = 1; tick();
        check("R7 acc hold", acc_q, 16'h3C3C);
        check("R7 addr hold", {4'h0, addr_q}, 16'h0155);
        check("R7 instr hold", instr_q, 16'h1234);
        check("R8 mem_we low", {15'h0, mem_we}, 16'h0000);
    endtask

    task automatic t_swap();
        bus_sel = 3'd7; mem_rdata = 16'h1111; data_ld = 1; tick();
        alu_result = 16'h2222; acc_ld = 1; tick();
        bus_sel = 3'd4; alu_result = data_q; data_ld = 1; acc_ld = 1; tick();
        check("R9 data gets acc", data_q, 16'h2222);
        check("R9 acc gets data", acc_q, 16'h1111);
        bus_sel = 3'd7; mem_rdata = 16'h5555; alu_result = 16'h6666; acc_ld = 1; tick();
        check("R4 acc from alu", acc_q, 16'h6666);
    endtask

    initial begin
        #(8 * 5000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_loads();
        t_select();
        t_char();
        t_priority();
        t_wrap();
        t_hold_mem();
        t_swap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule